// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Sequencer

This block steps a chip's built-in self-test through a list of sessions. Each session names a set of test jobs that start together. The block owns six test jobs, and each job has a fixed power weight and a fixed run length in clock cycles. A session is finished when its longest member has run its length. The sequencer then moves to the next entry in the list. The pattern generators and signature compactors that do the actual testing sit outside this block. They receive a one-cycle launch pulse and a busy window from it.

The schedule comes in as a table of up to eight entries. Each entry is a 6-bit test mask plus a valid flag. Bit i of a mask selects test i+1. The table is captured on a start pulse, and the first entry whose valid flag is clear ends the list. Each entry is screened before it launches. Its summed power must stay within the budget, and its members must all belong to one of the permitted co-run groups. If an entry fails the screen, the block stops with an error code, reports the cycles used so far, and launches none of that entry's tests. A clean run ends with a done level and the total count of cycles spent in sessions.

Test table (test: power, length): T1: 2, 100. T2: 1, 10. T3: 1, 10. T4: 1, 5. T5: 2, 10. T6: 1, 100. The power budget is 4.

The permitted co-run groups are {T2,T6}, {T1,T6}, {T2,T5}, {T1,T3,T4} and {T1,T3,T5}.

Top module: `bist_session_seq`

## Requirements
- R1: After reset, `done`, `error`, `err_code`, `test_go`, `test_busy` and `elapsed` are all zero.
- R2: When a session launches, `test_go` pulses for exactly one cycle. The pulse carries exactly that entry's mask, and entries launch in table order starting at entry 0.
- R3: `test_busy[i]` rises in the same cycle as `test_go[i]` and stays high for exactly that test's length: T1 100, T2 10, T3 10, T4 5, T5 10, T6 100 cycles.
- R4: A session lasts as long as its longest member. `elapsed` only grows during a run and finally equals the sum of the session maxima. For the schedule {T3,T4}, {T2,T5}, {T1,T6} it ends at 120.
- R5: An entry whose power sum exceeds 4 is rejected. `err_code` bit 0 is set, `error` goes high and no test of that entry is launched. A sum of exactly 4 is accepted.
- R6: An entry whose tests are not all inside one permitted group is rejected with `err_code` bit 1 set. A single entry can set both bits.
- R7: The first entry with its valid bit clear ends the schedule, and later entries are ignored even when they are valid. If entry 0 is invalid, `done` rises with `elapsed` equal to 0.
- R8: `done` (and likewise `error`) stays high until the next `start`. The `start` pulse clears both by the following cycle and begins a new run.
- R9: When all eight entries are valid and clean, all eight run and then `done` is raised.
- R10: A valid entry with an empty mask is rejected as a grouping fault (`err_code` bit 1).
- R11: While `done` or `error` is high, no `test_go` or `test_busy` bit is high, and `done` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Captures the table and begins a run. It is honoured only when the block is idle, done or halted |
| sess_mask_i | input | 48 | Entry k mask at bits [6k+5:6k]. Bit i selects test i+1 |
| sess_vld_i | input | 8 | Valid flag per entry |
| test_go | output | 6 | One-cycle launch pulse per test |
| test_busy | output | 6 | Per-test active window |
| done | output | 1 | Schedule completed |
| error | output | 1 | Halted on a rejected entry |
| err_code | output | 2 | Bit 0: over power budget. Bit 1: not a permitted group or empty |
| elapsed | output | 16 | Cycles spent in sessions |

## Verification
- **Wrong session index:** the launch mask is wrong on the very first `test_go` pulse of the affected session.
- **Bad duration count or missed run-to-next transition:** a busy window has the wrong length, or `elapsed` at completion differs from the sum of maxima. The length error shows when the window closes, and the `elapsed` error shows when `done` rises, at most a few hundred cycles later.
- **Wrong screening result:** either a rejected entry launches anyway, which the scoreboard catches at the unexpected pulse, or a clean schedule halts early, which shows as a wrong code and count at the stop.

// File: rtl/bist_seq_pkg.sv
// Package: constants, per-test ratings and co-run groups for the session sequencer.
// Assumes test i+1 maps to mask bit i throughout the project.
package bist_seq_pkg;

    localparam int NT    = 6;   // number of test jobs
    localparam int NG    = 5;   // number of permitted co-run groups
    localparam int PW_W  = 3;   // width of one power weight
    localparam int LEN_W = 8;   // width of one test length

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_RUN   = 3'd2,
        ST_NEXT  = 3'd3,
        ST_DONE  = 3'd4,
        ST_HALT  = 3'd5
    } seq_state_t;

    // Power weight of test index i (0-based)
    function automatic logic [PW_W-1:0] test_pwr(input int i);
        case (i)
            0: test_pwr = 3'd2;
            1: test_pwr = 3'd1;
            2: test_pwr = 3'd1;
            3: test_pwr = 3'd1;
            4: test_pwr = 3'd2;
            default: test_pwr = 3'd1;
        endcase
    endfunction

    // Run length of test index i in clock cycles
    function automatic logic [LEN_W-1:0] test_len(input int i);
        case (i)
            0: test_len = 8'd100;
            1: test_len = 8'd10;
            2: test_len = 8'd10;
            3: test_len = 8'd5;
            4: test_len = 8'd10;
            default: test_len = 8'd100;
        endcase
    endfunction

    // Member mask of permitted group g
    function automatic logic [NT-1:0] compat_group(input int g);
        case (g)
            0: compat_group = 6'b010101;  // T1 T3 T5
            1: compat_group = 6'b001101;  // T1 T3 T4
            2: compat_group = 6'b100001;  // T1 T6
            3: compat_group = 6'b010010;  // T2 T5
            default: compat_group = 6'b100010;  // T2 T6
        endcase
    endfunction

endpackage

// File: rtl/bist_sess_check.sv
// Session screen: sums the power of the selected tests, tests membership in
// the permitted groups and finds the longest member length.
// Purely combinational; assumes mask bit i selects test i+1.
module bist_sess_check
    import bist_seq_pkg::*;
#(
    parameter int PWR_LIMIT = 4
) (
    input  logic [NT-1:0]    mask,
    output logic             pwr_over,
    output logic             grp_bad,
    output logic [LEN_W-1:0] max_len
);

    localparam int SUM_W = PW_W + $clog2(NT + 1);

    logic [SUM_W-1:0] pwr_sum;
    logic [NG-1:0]    grp_hit;

    // Accumulate power and pick the longest selected length
    always_comb begin
        pwr_sum = '0;
        max_len = '0;
        for (int i = 0; i < NT; i++) begin
            if (mask[i]) begin
                pwr_sum = pwr_sum + SUM_W'(test_pwr(i));
                if (test_len(i) > max_len) max_len = test_len(i);
            end
        end
    end

    // One subset test per permitted group
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_hit[g] = ((mask & ~compat_group(g)) == '0);
    end

    assign pwr_over = (pwr_sum > SUM_W'(PWR_LIMIT));
    assign grp_bad  = (mask == '0) || (grp_hit == '0);

endmodule

// File: rtl/bist_test_timer.sv
// Per-test window timer: on load, busy goes high for exactly LEN cycles.
// Assumes LEN is non-zero.
module bist_test_timer
    import bist_seq_pkg::*;
#(
    parameter logic [LEN_W-1:0] LEN = 8'd10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    logic [LEN_W-1:0] cnt;

    // Load the length, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= LEN;
        else if (cnt != '0)   cnt <= cnt - LEN_W'(1);
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/bist_session_seq.sv
// Session sequencer top: captures the schedule on start, screens each entry,
// launches its tests, waits for the longest one, and ends in done or halt.
// Assumes the table is stable during the start cycle; start is ignored mid-run.
module bist_session_seq
    import bist_seq_pkg::*;
#(
    parameter int NUM_SESS  = 8,
    parameter int PWR_LIMIT = 4,
    parameter int ELAPSED_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_SESS*NT-1:0] sess_mask_i,
    input  logic [NUM_SESS-1:0]    sess_vld_i,
    output logic [NT-1:0]          test_go,
    output logic [NT-1:0]          test_busy,
    output logic                   done,
    output logic                   error,
    output logic [1:0]             err_code,
    output logic [ELAPSED_W-1:0]   elapsed
);

    localparam int IDX_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1;

    seq_state_t           state;
    logic [IDX_W-1:0]     idx;
    logic [NT-1:0]        mask_q [NUM_SESS];
    logic [NUM_SESS-1:0]  vld_q;
    logic [LEN_W-1:0]     sess_left;
    logic [NT-1:0]        cur_mask;
    logic                 pwr_over, grp_bad;
    logic [LEN_W-1:0]     max_len;
    logic [NT-1:0]        launch;
    logic                 can_start;

    assign cur_mask  = mask_q[idx];
    assign can_start = start && (state == ST_IDLE || state == ST_DONE || state == ST_HALT);

    // Screen the entry currently pointed at
    bist_sess_check #(.PWR_LIMIT(PWR_LIMIT)) u_check (
        .mask     (cur_mask),
        .pwr_over (pwr_over),
        .grp_bad  (grp_bad),
        .max_len  (max_len)
    );

    // Launch vector: the current mask when a valid entry passes the screen
    always_comb begin
        launch = '0;
        if (state == ST_CHECK && vld_q[idx] && !pwr_over && !grp_bad)
            launch = cur_mask;
    end

    // One window timer per test
    for (genvar i = 0; i < NT; i++) begin : g_tmr
        bist_test_timer #(.LEN(test_len(i))) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (launch[i]),
            .busy  (test_busy[i])
        );
    end

    // Capture the schedule table on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < NUM_SESS; k++) mask_q[k] <= '0;
        end else if (can_start) begin
            vld_q <= sess_vld_i;
            for (int k = 0; k < NUM_SESS; k++) mask_q[k] <= sess_mask_i[k*NT +: NT];
        end
    end

    // Sequencer state, session index, counters and launch pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            sess_left <= '0;
            elapsed   <= '0;
            err_code  <= '0;
            test_go   <= '0;
        end else begin
            test_go <= '0;
            case (state)
                ST_IDLE, ST_DONE, ST_HALT: begin
                    if (can_start) begin
                        idx      <= '0;
                        elapsed  <= '0;
                        err_code <= '0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!vld_q[idx]) begin
                        state <= ST_DONE;
                    end else if (pwr_over || grp_bad) begin
                        err_code <= {grp_bad, pwr_over};
                        state    <= ST_HALT;
                    end else begin
                        test_go   <= launch;
                        sess_left <= max_len;
                        state     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    elapsed   <= elapsed + ELAPSED_W'(1);
                    sess_left <= sess_left - LEN_W'(1);
                    if (sess_left <= LEN_W'(1)) state <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (idx == IDX_W'(NUM_SESS - 1)) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done  = (state == ST_DONE);
    assign error = (state == ST_HALT);

endmodule

// File: rtl/bist_session_seq_chk.sv
// Checker for the session sequencer: port-level temporal properties.
// Assumes the synchronous active-low reset of the top module.
module bist_session_seq_chk
    import bist_seq_pkg::*;
#(
    parameter int ELAPSED_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [NT-1:0]        test_go,
    input logic [NT-1:0]        test_busy,
    input logic                 done,
    input logic                 error,
    input logic [ELAPSED_W-1:0] elapsed
);

    // R2: a launch pulse lasts one cycle
    a_r2_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        (test_go != '0) |=> (test_go == '0));

    // R3: each launched test is busy in its launch cycle
    for (genvar i = 0; i < NT; i++) begin : g_go
        a_r3_busy_with_go: assert property (@(posedge clk) disable iff (!rst_n)
            test_go[i] |-> test_busy[i]);
    end

    // R4: elapsed never decreases without a start
    a_r4_elapsed_grows: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (elapsed >= $past(elapsed)));

    // R8: done held until start
    a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8: error held until start
    a_r8_error_held: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R11: quiet outputs once finished or halted
    a_r11_quiet_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (test_go == '0 && test_busy == '0));

    // R11: done and error exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

endmodule

bind bist_session_seq bist_session_seq_chk #(.ELAPSED_W(ELAPSED_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .test_go   (test_go),
    .test_busy (test_busy),
    .done      (done),
    .error     (error),
    .elapsed   (elapsed)
);

// File: tb/sim_bist_session_seq.sv
module sim_bist_session_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] sess_mask_i = '0;
    logic [7:0]  sess_vld_i = '0;
    logic [5:0]  test_go, test_busy;
    logic        done, error;
    logic [1:0]  err_code;
    logic [15:0] elapsed;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_q[$];
    int run_len[6];
    int exp_len[6] = '{100, 10, 10, 5, 10, 100};

    always #2 clk = ~clk;  // 250 MHz

    bist_session_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sess_mask_i(sess_mask_i), .sess_vld_i(sess_vld_i),
        .test_go(test_go), .test_busy(test_busy),
        .done(done), .error(error), .err_code(err_code), .elapsed(elapsed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: launch pulses against the scoreboard, busy windows against lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (test_go != '0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected launch", int'(test_go), 0);
                end else begin
                    logic [5:0] e;
                    e = exp_q.pop_front();
                    chk(test_go == e, "R2 launch mask", int'(test_go), int'(e));
                end
            end
            for (int i = 0; i < 6; i++) begin
                if (test_busy[i]) run_len[i]++;
                else if (run_len[i] != 0) begin
                    chk(run_len[i] == exp_len[i], "R3 busy length", run_len[i], exp_len[i]);
                    run_len[i] = 0;
                end
            end
        end
    end

    // Driver: queue expected launches, pulse start, wait for the end, compare
    task automatic run_case(input logic [5:0] m[8], input logic [7:0] v, input int n_launch,
                            input int exp_el, input logic [1:0] exp_err, input string req);
        int wait_n;
        for (int k = 0; k < 8; k++) sess_mask_i[k*6 +: 6] = m[k];
        sess_vld_i = v;
        for (int k = 0; k < n_launch; k++) exp_q.push_back(m[k]);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !error, "R8 start clears", int'({done, error}), 0);
        wait_n = 0;
        while (!(done || error) && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(wait_n < 5000, {req, " finish"}, wait_n, 5000);
        chk(exp_q.size() == 0, {req, " all launched"}, exp_q.size(), 0);
        exp_q.delete();
        chk(int'(elapsed) == exp_el, {req, " elapsed"}, int'(elapsed), exp_el);
        chk(error == (exp_err != 0), {req, " error flag"}, int'(error), int'(exp_err != 0));
        chk(done == (exp_err == 0), {req, " done flag"}, int'(done), int'(exp_err == 0));
        chk(err_code == exp_err, {req, " err_code"}, int'(err_code), int'(exp_err));
        repeat (4) @(negedge clk);
        chk((done || error) && test_busy == 0, "R8 R11 held quiet", int'(test_busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] m[8];
        for (int i = 0; i < 6; i++) run_len[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !error && err_code == 0 && test_go == 0 && test_busy == 0 && elapsed == 0,
            "R1 reset state", int'({done, error, err_code, test_go, test_busy}), 0);

        // R4 default schedule: {T3,T4}, {T2,T5}, {T1,T6} -> 120
        m = '{6'b001100, 6'b010010, 6'b100001, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0111, 3, 120, 2'b00, "R4");

        // R5 power exactly at budget: {T1,T3,T4} -> 100
        m = '{6'b001101, 0, 0, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0001, 1, 100, 2'b00, "R5 boundary");

        // R5 over budget in second entry: {T4} then {T1,T3,T5}
        m = '{6'b001000, 6'b010101, 0, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0011, 1, 5, 2'b01, "R5");

        // R6 not a permitted group: {T1,T2}
        m = '{6'b000011, 0, 0, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0001, 0, 0, 2'b10, "R6");

        // R6 both faults: {T1,T2,T5}
        m = '{6'b010011, 0, 0, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0001, 0, 0, 2'b11, "R6 both");

        // R10 empty valid entry
        m = '{6'b000010, 6'b000000, 0, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0011, 1, 10, 2'b10, "R10");

        // R7 entry 0 invalid
        m = '{6'b000001, 0, 0, 0, 0, 0, 0, 0};
        run_case(m, 8'b0000_0000, 0, 0, 2'b00, "R7 empty list");

        // R7 gap at entry 2 hides later valid entries
        m = '{6'b000010, 6'b100000, 6'b000001, 6'b000001, 6'b000001, 6'b000001, 6'b000001, 6'b000001};
        run_case(m, 8'b1111_1011, 2, 110, 2'b00, "R7 gap");

        // R9 all eight valid
        m = '{6'b010000, 6'b100010, 6'b001000, 6'b010100,
              6'b000001, 6'b000010, 6'b001000, 6'b100000};
        run_case(m, 8'b1111_1111, 8, 340, 2'b00, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule